// File: doc/BRIEF.md
# Per-Flow Cell Load Balancer

This unit sits at an input switching element of a three-stage Clos packet switch and decides which centre-stage element each arriving cell will cross. Every cell arrives with a flow identifier. The unit keeps a small counter for each flow, tags the cell with that flow's current counter value as the centre index, and then steps the counter, so that successive cells of one flow are spread round-robin over all centre elements.

Switching elements are aligned only at frame granularity, and cells tagged during one frame are carried forward by the fabric in the following frame. At every frame boundary all flow counters are reloaded to staggered starting values, (anchor + flow) mod l, where the anchor is the index of the switching element that owns the counters. Staggering keeps all flows from beginning a frame on the same centre element. The same unit serves an output-side placement by setting the anchor to the destination element index.

The tag leaves one cycle after the cell, as a valid flag with the flow id and centre index side by side. At most one cell is accepted per cycle.

Top module: `lb_cell_spreader`

## Requirements
- R1: Each flow id in 0 to NUM_FLOWS-1 has its own counter; a cell of one flow never changes the centre sequence seen by any other flow.
- R2: When cell_vld is high at a clock edge, tag_vld is high after that edge for one cycle, tag_flow equals the flow id sampled at that edge, and tag_centre equals that flow's counter value before the edge.
- R3: After a flow is tagged, its counter becomes (value + 1) mod NUM_CENTRE, so a value of NUM_CENTRE-1 wraps to 0, also when NUM_CENTRE is not a power of two.
- R4: A frame_start pulse sets the counter of every flow g to (ANCHOR_IDX + g) mod NUM_CENTRE.
- R5: When frame_start and cell_vld are high in the same cycle, the cell is tagged with its flow's frame-start value, and that flow's counter then holds the frame-start value plus one, modulo NUM_CENTRE.
- R6: While rst is high at a clock edge, all counters are set to their frame-start values and tag_vld is low after that edge; no cell presented in that cycle is tagged.
- R7: A cycle with cell_vld low yields tag_vld low after the next edge and leaves every counter unchanged.
- R8: tag_centre is always below NUM_CENTRE whenever tag_vld is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | One-cycle pulse marking a frame boundary |
| cell_vld | input | 1 | A cell arrives this cycle |
| cell_flow | input | FLOW_W | Flow id of the arriving cell |
| tag_vld | output | 1 | A tag is presented |
| tag_flow | output | FLOW_W | Flow id the tag belongs to |
| tag_centre | output | CTR_W | Centre-stage element the cell must cross |

## Verification
The hardest situation to reach from the ports is a frame boundary that coincides with a cell whose flow counter is part-way through its round, since only then does the reload have to win over the step while the step still applies to the reloaded value. The stimulus first drives a flow several cells away from its start value and then raises frame_start and cell_vld together, and repeats this on a flow already at the wrap point. A centre count that is not a power of two is used so the wrap from NUM_CENTRE-1 to 0 cannot be hidden by natural binary overflow, and a long random phase mixes boundaries, resets and idle cycles against a behavioural model.

// File: rtl/lb_pkg.sv
package lb_pkg;

  // Frame-start value of a flow's counter: staggered by the anchor index.
  function automatic int unsigned lb_start_val(int unsigned anchor,
                                               int unsigned flow,
                                               int unsigned centres);
    return (anchor + flow) % centres;
  endfunction

  // One round-robin step over the centre elements.
  function automatic int unsigned lb_next_val(int unsigned value,
                                              int unsigned centres);
    return (value + 1 >= centres) ? 0 : value + 1;
  endfunction

  // Width of an index able to hold 0 .. count-1 (at least one bit).
  function automatic int unsigned lb_idx_w(int unsigned count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/lb_flow_ctr.sv
module lb_flow_ctr
  import lb_pkg::*;
#(
  parameter int unsigned NUM_CENTRE = 8,
  parameter int unsigned CTR_W      = 3,
  parameter logic [CTR_W-1:0] START = '0
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             bump,
  output logic [CTR_W-1:0] value
);

  localparam logic [CTR_W-1:0] START_NEXT =
    CTR_W'(lb_next_val(32'(START), NUM_CENTRE));

  logic [CTR_W-1:0] stepped;
  logic [CTR_W-1:0] value_d;

  assign stepped = CTR_W'(lb_next_val(32'(value), NUM_CENTRE));

  always_comb begin
    value_d = value;
    if (load && bump)      value_d = START_NEXT;
    else if (load)         value_d = START;
    else if (bump)         value_d = stepped;
  end

  always_ff @(posedge clk) begin
    if (rst) value <= START;
    else     value <= value_d;
  end

  // R4: a frame boundary without a cell reloads the staggered start
  p_frame_load_r4: assert property (@(posedge clk) disable iff (rst)
    (load && !bump) |=> (value == START));

  // R3: a tagged cell steps the counter modulo the centre count
  p_step_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (bump && !load) |=>
      (value == CTR_W'(lb_next_val(32'($past(value)), NUM_CENTRE))));

  // R5: coincident boundary and cell leaves start plus one
  p_coincide_r5: assert property (@(posedge clk) disable iff (rst)
    (load && bump) |=> (value == START_NEXT));

  // R1, R7: an untouched counter keeps its value
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!load && !bump) |=> $stable(value));

  // R6: reset forces the start value
  p_reset_r6: assert property (@(posedge clk)
    rst |=> (value == START));

endmodule

// File: rtl/lb_tag_stage.sv
module lb_tag_stage #(
  parameter int unsigned FLOW_W = 4,
  parameter int unsigned CTR_W  = 3
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [FLOW_W-1:0] in_flow,
  input  logic [CTR_W-1:0]  in_centre,
  output logic              out_vld,
  output logic [FLOW_W-1:0] out_flow,
  output logic [CTR_W-1:0]  out_centre
);

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      out_flow   <= in_flow;
      out_centre <= in_centre;
    end
  end

  // R6: nothing is tagged in the cycle after reset
  p_quiet_after_rst_r6: assert property (@(posedge clk)
    rst |=> !out_vld);

endmodule

// File: rtl/lb_cell_spreader.sv
module lb_cell_spreader
  import lb_pkg::*;
#(
  parameter int unsigned ANCHOR_IDX = 0,
  parameter int unsigned NUM_FLOWS  = 16,
  parameter int unsigned NUM_CENTRE = 8,
  localparam int unsigned FLOW_W    = lb_idx_w(NUM_FLOWS),
  localparam int unsigned CTR_W     = lb_idx_w(NUM_CENTRE)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              cell_vld,
  input  logic [FLOW_W-1:0] cell_flow,
  output logic              tag_vld,
  output logic [FLOW_W-1:0] tag_flow,
  output logic [CTR_W-1:0]  tag_centre
);

  // Named internal events, used by the assertions below.
  logic              frame_hit;
  logic              cell_hit;
  logic              flow_ok;
  logic [CTR_W-1:0]  cur_val;
  logic [CTR_W-1:0]  start_val;
  logic [CTR_W-1:0]  tag_next;
  logic [CTR_W-1:0]  ctr_val [NUM_FLOWS];
  logic [NUM_FLOWS-1:0] bump_vec;

  assign frame_hit = frame_start;
  assign cell_hit  = cell_vld;
  assign flow_ok   = (32'(cell_flow) < NUM_FLOWS);

  for (genvar g = 0; g < NUM_FLOWS; g++) begin : g_flow
    localparam logic [CTR_W-1:0] START_G =
      CTR_W'(lb_start_val(ANCHOR_IDX, g, NUM_CENTRE));

    assign bump_vec[g] = cell_hit && (32'(cell_flow) == g);

    lb_flow_ctr #(
      .NUM_CENTRE (NUM_CENTRE),
      .CTR_W      (CTR_W),
      .START      (START_G)
    ) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .load  (frame_hit),
      .bump  (bump_vec[g]),
      .value (ctr_val[g])
    );
  end

  always_comb begin
    cur_val = '0;
    for (int g = 0; g < NUM_FLOWS; g++) begin
      if (32'(cell_flow) == g) cur_val = ctr_val[g];
    end
  end

  assign start_val = flow_ok ?
    CTR_W'(lb_start_val(ANCHOR_IDX, 32'(cell_flow), NUM_CENTRE)) : '0;
  assign tag_next  = frame_hit ? start_val : cur_val;

  lb_tag_stage #(
    .FLOW_W (FLOW_W),
    .CTR_W  (CTR_W)
  ) u_tag (
    .clk        (clk),
    .rst        (rst),
    .in_vld     (cell_hit),
    .in_flow    (cell_flow),
    .in_centre  (tag_next),
    .out_vld    (tag_vld),
    .out_flow   (tag_flow),
    .out_centre (tag_centre)
  );

  // R2: one-cycle latency, flow id carried with the tag
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    cell_hit |=> (tag_vld && tag_flow == $past(cell_flow)));

  // R7: no cell, no tag
  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !cell_hit |=> !tag_vld);

  // R8: centre index stays in range
  p_range_r8: assert property (@(posedge clk) disable iff (rst)
    tag_vld |-> (32'(tag_centre) < NUM_CENTRE));

  // R5: a cell at a frame boundary gets its flow's staggered start
  p_boundary_tag_r5: assert property (@(posedge clk) disable iff (rst)
    (cell_hit && frame_hit && flow_ok) |=>
      (32'(tag_centre) ==
       lb_start_val(ANCHOR_IDX, 32'($past(cell_flow)), NUM_CENTRE)));

endmodule

// File: tb/sim_lb_cell_spreader.sv
module sim_lb_cell_spreader;

  localparam int ANCHOR = 5;
  localparam int G      = 12;
  localparam int L      = 6;
  localparam int FW     = 4;
  localparam int CW     = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_start = 1'b0;
  logic          cell_vld = 1'b0;
  logic [FW-1:0] cell_flow = '0;
  logic          tag_vld;
  logic [FW-1:0] tag_flow;
  logic [CW-1:0] tag_centre;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Behavioural reference state
  int m_cnt [G];
  bit e_vld;
  int e_flow;
  int e_centre;

  always #5 clk = ~clk;

  lb_cell_spreader #(
    .ANCHOR_IDX (ANCHOR),
    .NUM_FLOWS  (G),
    .NUM_CENTRE (L)
  ) u0 (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .cell_vld    (cell_vld),
    .cell_flow   (cell_flow),
    .tag_vld     (tag_vld),
    .tag_flow    (tag_flow),
    .tag_centre  (tag_centre)
  );

  function automatic int first_val(int g);
    int v = ANCHOR;
    for (int k = 0; k < g; k++) v = (v == L - 1) ? 0 : v + 1;
    return v;
  endfunction

  task automatic model_edge(bit r, bit fs, bit cv, int f);
    if (r) begin
      for (int g = 0; g < G; g++) m_cnt[g] = first_val(g);
      e_vld = 0;
      return;
    end
    if (fs) for (int g = 0; g < G; g++) m_cnt[g] = first_val(g);
    e_vld = cv;
    if (cv) begin
      e_flow   = f;
      e_centre = m_cnt[f];
      m_cnt[f] = m_cnt[f] + 1;
      if (m_cnt[f] >= L) m_cnt[f] = 0;
    end
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drive one cycle, update the model at the edge, compare half a cycle later.
  task automatic step(string req, bit r, bit fs, bit cv, int f);
    rst         = r;
    frame_start = fs;
    cell_vld    = cv;
    cell_flow   = FW'(f);
    @(posedge clk);
    model_edge(r, fs, cv, f);
    @(negedge clk);
    check(req, "tag_vld", int'(tag_vld), int'(e_vld));
    if (e_vld) begin
      check(req, "tag_flow", int'(tag_flow), e_flow);
      check(req, "tag_centre", int'(tag_centre), e_centre);
      check("R8", "centre in range", int'(tag_centre < CW'(L)), 1);
    end
  endtask

  initial begin
    @(negedge clk);
    // R6: reset state
    step("R6", 1, 0, 0, 0);
    step("R6", 1, 0, 1, 3);
    // R7: idle cycles produce nothing
    for (int k = 0; k < 3; k++) step("R7", 0, 0, 0, 0);
    // R2, R3: one flow repeatedly, through the wrap from L-1 to 0
    for (int k = 0; k < 2 * L + 1; k++) step("R3", 0, 0, 1, 2);
    // R1: interleaved flows keep independent sequences
    for (int k = 0; k < 3 * G; k++) step("R1", 0, 0, 1, (k * 5) % G);
    // R7: idle with counters mid-round, then same flow resumes
    step("R7", 0, 0, 0, 2);
    step("R7", 0, 0, 0, 2);
    step("R2", 0, 0, 1, 2);
    // R4: frame boundary alone, then every flow tagged once
    step("R4", 0, 1, 0, 0);
    for (int g = 0; g < G; g++) step("R4", 0, 0, 1, g);
    // R5: advance flow 7 part-way, then boundary and cell together
    for (int k = 0; k < 3; k++) step("R5", 0, 0, 1, 7);
    step("R5", 0, 1, 1, 7);
    step("R5", 0, 0, 1, 7);
    // R5 with a flow whose start is L-1 (flow 0 when ANCHOR = L-1)
    step("R5", 0, 1, 1, 0);
    step("R5", 0, 0, 1, 0);
    step("R5", 0, 0, 1, 0);
    // R6: reset mid-run discards the cell and restores start values
    for (int k = 0; k < 4; k++) step("R6", 0, 0, 1, 9);
    step("R6", 1, 0, 1, 9);
    step("R6", 0, 0, 1, 9);
    // Mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      bit r  = ($urandom_range(0, 199) == 0);
      bit fs = ($urandom_range(0, 29) == 0);
      bit cv = ($urandom_range(0, 3) != 0);
      step("R2", r, fs, cv, $urandom_range(0, G - 1));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule